// File: doc/BRIEF.md
# Shared Input Stream Distributor

This block takes one upstream token stream and hands it to the partitions of a state machine that has been split into several pieces, of which only one runs at a time. Each partition has its own downstream valid/ready stream and two plain control pins: `part_active` says which partition currently holds control (at most one bit set), and `part_req` says that a partition wants a token now. The goal is that every partition sees the tokens it consumes in stream order, even though control moves between partitions.

A parameter picks one of two schemes. In broadcast mode every token is offered to every partition. A partition that has just lost control is loaded with a discard count, taken from its `drop_num` field. The distributor then accepts and throws away that many tokens on that partition's behalf, so the partition does not see tokens that belong to another partition's run. In directed mode a token goes only to the partition that is active and requesting. A second parameter adds a one-token prefetch register. The register fills whenever it is empty and holds its token across a change of control, so the partition that takes over receives the token.

Back-pressure rules: upstream, a token is consumed only in a cycle with `in_valid` and `in_ready` both high. The upstream source must hold `in_valid` and `in_data` steady until that cycle. Downstream, partition i takes a token in a cycle with `out_valid[i]` and `out_ready[i]` both high. In broadcast mode the upstream stays stalled until every partition has either taken or dropped the current token.

Top module: `stream_distributor`

## Requirements
- R1: With reset held and then released, and `in_valid` low, every `out_valid` bit is 0. In the prefetch variant `in_ready` is 1 because the buffer is empty.
- R2: In broadcast mode, a pending token is offered on `out_valid[i]` of every partition that is not discarding and has not yet taken it. Every `out_data` slice equals `in_data`. Slice i is bits [i*WIDTH +: WIDTH].
- R3: In broadcast mode, `in_ready` is 1 only in a cycle in which every partition has taken or dropped the current token, now or in an earlier cycle. A partition that took the token earlier sees `out_valid` low for the rest of that token.
- R4: In broadcast mode, partition i's discard counter is loaded with `drop_num[i*CNT_W +: CNT_W]` at the first clock edge that samples `part_active[i]` low after it was high. While the counter is nonzero, `out_valid[i]` stays low, the token counts as accepted by partition i whatever `out_ready[i]` is, and the counter drops by one per token. Delivery resumes when the counter reaches 0.
- R5: In broadcast mode, the first clock edge that samples `part_active[i]` high after it was low clears partition i's discard counter. Tokens then reach partition i again.
- R6: In directed mode, at most one `out_valid` bit is high. `out_valid[i]` is high only when `part_active[i]` and `part_req[i]` are both 1 and a token is available.
- R7: In the directed request variant, the token passes straight through: `in_ready` equals `out_ready` of the partition that is active and requesting. With no such partition, `in_ready` is 0 and the token waits.
- R8: In the directed prefetch variant, `in_ready` is 1 when the buffer is empty, or in the cycle in which the buffered token is taken. A captured token is offered from the next cycle on.
- R9: In the directed prefetch variant, a buffered token is kept unchanged across a change of `part_active`. It is delivered to the partition that is active and requesting afterwards, ahead of any later token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream token valid |
| in_ready | output | 1 | Upstream token accepted when high with in_valid |
| in_data | input | WIDTH | Upstream token |
| out_valid | output | NPART | Per-partition token valid |
| out_ready | input | NPART | Per-partition token ready |
| out_data | output | NPART*WIDTH | Per-partition token, slice i for partition i |
| part_active | input | NPART | Partition holding control, at most one bit set |
| part_req | input | NPART | Partition asks for a token (directed mode) |
| drop_num | input | NPART*CNT_W | Discard count loaded when a partition goes inactive (broadcast mode) |

## Verification
The bench builds three copies of the block, all with two partitions and 8-bit tokens. The first is broadcast mode with a 3-bit discard count. It covers partial acceptance across partitions, a counter loaded and then cleared by re-activation before any token arrives, and a countdown that ends part way through a burst. The second is the directed request variant, which shows a token waiting with no request and a request from an inactive partition being ignored. The third is the prefetch variant, which shows a token captured with no request pending and then carried across a handoff to the other partition.

// File: rtl/stream_dist_pkg.sv
package stream_dist_pkg;
  typedef enum logic {
    DIST_BCAST  = 1'b0,
    DIST_DIRECT = 1'b1
  } dist_mode_e;
endpackage

// File: rtl/dist_bcast_lane.sv
module dist_bcast_lane #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic             fire_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] drop_num_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             done_o
);
  logic             taken_q;
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dropping;
  logic             acc;

  assign dropping    = (cnt_q != '0);
  assign acc         = in_valid_i && !taken_q && (dropping || out_ready_i);
  assign out_valid_o = in_valid_i && !taken_q && !dropping;
  assign done_o      = taken_q || acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      act_q <= active_i;
      if (fire_i)   taken_q <= 1'b0;
      else if (acc) taken_q <= 1'b1;
      if (act_q && !active_i)       cnt_q <= drop_num_i;
      else if (!act_q && active_i)  cnt_q <= '0;
      else if (acc && dropping)     cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: a partition that took the token is not offered it again
  assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !fire_i) |=> !out_valid_o);
  // R4: counter takes the discard count when control is lost
  assert_drop_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !active_i) |=> (cnt_q == $past(drop_num_i)));
  // R4: a discarding partition never holds back the stream
  assert_drop_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dropping && in_valid_i) |-> (done_o && !out_valid_o));
  // R5: gaining control clears the counter
  assert_rearm_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && active_i) |=> (cnt_q == '0));
endmodule

// File: rtl/dist_direct_path.sv
module dist_direct_path #(
  parameter int WIDTH    = 8,
  parameter int NPART    = 2,
  parameter bit PREFETCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [WIDTH-1:0] in_data_i,
  output logic             in_ready_o,
  input  logic [NPART-1:0] active_i,
  input  logic [NPART-1:0] req_i,
  input  logic [NPART-1:0] out_ready_i,
  output logic [NPART-1:0] out_valid_o,
  output logic [WIDTH-1:0] out_data_o
);
  logic [NPART-1:0] grant;
  assign grant = active_i & req_i;

  generate
    if (PREFETCH) begin : g_prefetch
      logic             buf_v;
      logic [WIDTH-1:0] buf_d;
      logic             pop;
      assign out_valid_o = buf_v ? grant : '0;
      assign out_data_o  = buf_d;
      assign pop         = |(out_valid_o & out_ready_i);
      assign in_ready_o  = !buf_v || pop;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          buf_v <= 1'b0;
          buf_d <= '0;
        end else if (in_valid_i && in_ready_o) begin
          buf_v <= 1'b1;
          buf_d <= in_data_i;
        end else if (pop) begin
          buf_v <= 1'b0;
        end
      end

      // R9: an untaken token stays put whatever control does
      assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_v && !pop) |=> (buf_v && $stable(buf_d)));
      // R8: a full buffer admits a token only while it drains
      assert_ready_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && buf_v) |-> pop);
    end else begin : g_request
      assign out_valid_o = in_valid_i ? grant : '0;
      assign out_data_o  = in_data_i;
      assign in_ready_o  = |(grant & out_ready_i);
      // R7: with nobody requesting the stream waits
      assert_wait_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> !in_ready_o);
    end
  endgenerate

  // R6: tokens go to one active, requesting partition only
  assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid_o) && ((out_valid_o & ~grant) == '0));
endmodule

// File: rtl/stream_distributor.sv
module stream_distributor
  import stream_dist_pkg::*;
#(
  parameter int         WIDTH    = 8,
  parameter int         NPART    = 2,
  parameter int         CNT_W    = 4,
  parameter dist_mode_e MODE     = DIST_BCAST,
  parameter bit         PREFETCH = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WIDTH-1:0]       in_data,
  output logic [NPART-1:0]       out_valid,
  input  logic [NPART-1:0]       out_ready,
  output logic [NPART*WIDTH-1:0] out_data,
  input  logic [NPART-1:0]       part_active,
  input  logic [NPART-1:0]       part_req,
  input  logic [NPART*CNT_W-1:0] drop_num
);
  logic [WIDTH-1:0] tok_data;

  generate
    if (MODE == DIST_BCAST) begin : g_bcast
      logic [NPART-1:0] done;
      logic             fire;
      logic             unused_req;
      assign unused_req = ^part_req;
      assign in_ready   = &done;
      assign fire       = in_valid && in_ready;
      assign tok_data   = in_data;
      for (genvar i = 0; i < NPART; i++) begin : g_lane
        dist_bcast_lane #(.CNT_W(CNT_W)) lane_i (
          .clk         (clk),
          .rst_n       (rst_n),
          .in_valid_i  (in_valid),
          .fire_i      (fire),
          .active_i    (part_active[i]),
          .drop_num_i  (drop_num[i*CNT_W +: CNT_W]),
          .out_ready_i (out_ready[i]),
          .out_valid_o (out_valid[i]),
          .done_o      (done[i])
        );
      end
    end else begin : g_direct
      logic unused_drop;
      assign unused_drop = ^drop_num;
      dist_direct_path #(.WIDTH(WIDTH), .NPART(NPART), .PREFETCH(PREFETCH)) path_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_ready_o  (in_ready),
        .active_i    (part_active),
        .req_i       (part_req),
        .out_ready_i (out_ready),
        .out_valid_o (out_valid),
        .out_data_o  (tok_data)
      );
    end
    for (genvar j = 0; j < NPART; j++) begin : g_fan
      assign out_data[j*WIDTH +: WIDTH] = tok_data;
    end
  endgenerate

  // R6: control is held by at most one partition
  assert_active_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(part_active));
endmodule

// File: tb/stream_distributor_tb.sv
module stream_distributor_tb_top;
  import stream_dist_pkg::*;
  localparam int W = 8;
  localparam int N = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // broadcast copy
  logic b_iv, b_ir;
  logic [W-1:0] b_id;
  logic [N-1:0] b_ov, b_or, b_act, b_req;
  logic [N*W-1:0] b_od;
  logic [N*CW-1:0] b_drop;
  // directed request copy
  logic r_iv, r_ir;
  logic [W-1:0] r_id;
  logic [N-1:0] r_ov, r_or, r_act, r_req;
  logic [N*W-1:0] r_od;
  // directed prefetch copy
  logic p_iv, p_ir;
  logic [W-1:0] p_id;
  logic [N-1:0] p_ov, p_or, p_act, p_req;
  logic [N*W-1:0] p_od;

  stream_distributor #(.WIDTH(W), .NPART(N), .CNT_W(CW), .MODE(DIST_BCAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir), .in_data(b_id),
    .out_valid(b_ov), .out_ready(b_or), .out_data(b_od),
    .part_active(b_act), .part_req(b_req), .drop_num(b_drop));

  stream_distributor #(.WIDTH(W), .NPART(N), .CNT_W(CW), .MODE(DIST_DIRECT), .PREFETCH(1'b0)) dut_rq_i (
    .clk(clk), .rst_n(rst_n), .in_valid(r_iv), .in_ready(r_ir), .in_data(r_id),
    .out_valid(r_ov), .out_ready(r_or), .out_data(r_od),
    .part_active(r_act), .part_req(r_req), .drop_num('0));

  stream_distributor #(.WIDTH(W), .NPART(N), .CNT_W(CW), .MODE(DIST_DIRECT), .PREFETCH(1'b1)) dut_pf_i (
    .clk(clk), .rst_n(rst_n), .in_valid(p_iv), .in_ready(p_ir), .in_data(p_id),
    .out_valid(p_ov), .out_ready(p_or), .out_data(p_od),
    .part_active(p_act), .part_req(p_req), .drop_num('0));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    b_iv = 0; b_id = '0; b_or = '0; b_act = 2'b01; b_req = '0; b_drop = '0;
    r_iv = 0; r_id = '0; r_or = '0; r_act = 2'b01; r_req = '0;
    p_iv = 0; p_id = '0; p_or = '0; p_act = 2'b01; p_req = '0;
    rst_n = 0;
    repeat (3) settle();
    rst_n = 1;
    settle(); #1;
    chk(b_ov == 2'b00, "R1 bcast out_valid after reset", 32'(b_ov), 0);
    chk(r_ov == 2'b00, "R1 request out_valid after reset", 32'(r_ov), 0);
    chk(p_ov == 2'b00, "R1 prefetch out_valid after reset", 32'(p_ov), 0);
    chk(p_ir == 1'b1, "R1 prefetch in_ready after reset", 32'(p_ir), 1);
  endtask

  task automatic t_bcast_basic();
    settle();
    b_iv = 1; b_id = 8'hA5; b_or = 2'b11; #1;
    chk(b_ov == 2'b11, "R2 both offered", 32'(b_ov), 3);
    chk(b_od == {8'hA5, 8'hA5}, "R2 both slices carry token", 32'(b_od), 32'hA5A5);
    chk(b_ir == 1'b1, "R3 ready when all take", 32'(b_ir), 1);
    settle();
    b_id = 8'h5A; b_or = 2'b01; #1;
    chk(b_ir == 1'b0, "R3 stall on partition 1", 32'(b_ir), 0);
    settle(); #1;
    chk(b_ov == 2'b10, "R3 partition 0 not offered again", 32'(b_ov), 2);
    chk(b_ir == 1'b0, "R3 still stalled", 32'(b_ir), 0);
    b_or = 2'b10; #1;
    chk(b_ir == 1'b1, "R3 ready once last partition takes", 32'(b_ir), 1);
    settle();
    b_iv = 0; #1;
    chk(b_ov == 2'b00, "R3 no offer after completion", 32'(b_ov), 0);
  endtask

  task automatic t_bcast_drop();
    settle();
    b_drop = {3'd0, 3'd2}; b_act = 2'b10;   // partition 0 loses control: loads 2
    settle();
    b_act = 2'b01;                           // regains control before any token
    settle();
    b_iv = 1; b_id = 8'h31; b_or = 2'b11; #1;
    chk(b_ov == 2'b11, "R5 counter cleared on regaining control", 32'(b_ov), 3);
    settle();
    b_iv = 0; b_act = 2'b10;                 // loads 2 again
    settle();
    b_iv = 1; b_id = 8'h41; b_or = 2'b10; #1;
    chk(b_ov == 2'b10, "R4 first token dropped for partition 0", 32'(b_ov), 2);
    chk(b_ir == 1'b1, "R4 drop counts as accepted", 32'(b_ir), 1);
    settle();
    b_id = 8'h42; #1;
    chk(b_ov == 2'b10, "R4 second token dropped", 32'(b_ov), 2);
    chk(b_ir == 1'b1, "R4 second drop accepted", 32'(b_ir), 1);
    settle();
    b_id = 8'h43; #1;
    chk(b_ov == 2'b11, "R4 delivery resumes after count", 32'(b_ov), 3);
    chk(b_ir == 1'b0, "R4 waits for partition 0 again", 32'(b_ir), 0);
    b_or = 2'b11; #1;
    chk(b_ir == 1'b1, "R4 accepted after both ready", 32'(b_ir), 1);
    settle();
    b_iv = 0;
  endtask

  task automatic t_request();
    settle();
    r_iv = 1; r_id = 8'h77; r_act = 2'b01; r_req = 2'b00; r_or = 2'b11; #1;
    chk(r_ov == 2'b00, "R7 no request no offer", 32'(r_ov), 0);
    chk(r_ir == 1'b0, "R7 token waits without request", 32'(r_ir), 0);
    r_req = 2'b10; #1;
    chk(r_ov == 2'b00, "R6 inactive requester ignored", 32'(r_ov), 0);
    chk(r_ir == 1'b0, "R7 inactive requester gives no ready", 32'(r_ir), 0);
    r_req = 2'b01; #1;
    chk(r_ov == 2'b01, "R6 active requester offered", 32'(r_ov), 1);
    chk(r_od[7:0] == 8'h77, "R6 data to active partition", 32'(r_od[7:0]), 32'h77);
    chk(r_ir == 1'b1, "R7 ready follows partition ready", 32'(r_ir), 1);
    settle();
    r_id = 8'h78; r_act = 2'b10; r_req = 2'b10; r_or = 2'b01; #1;
    chk(r_ov == 2'b10, "R6 after handoff goes to partition 1", 32'(r_ov), 2);
    chk(r_ir == 1'b0, "R7 stalled by partition 1 ready", 32'(r_ir), 0);
    settle();
    r_iv = 0;
  endtask

  task automatic t_prefetch();
    settle();
    p_iv = 1; p_id = 8'h11; p_act = 2'b01; p_req = 2'b00; p_or = 2'b11; #1;
    chk(p_ir == 1'b1, "R8 empty buffer accepts without request", 32'(p_ir), 1);
    chk(p_ov == 2'b00, "R8 not offered in capture cycle", 32'(p_ov), 0);
    settle();
    p_id = 8'h22; #1;
    chk(p_ir == 1'b0, "R8 full buffer blocks upstream", 32'(p_ir), 0);
    chk(p_ov == 2'b00, "R6 no offer without request", 32'(p_ov), 0);
    settle();
    p_act = 2'b10; p_req = 2'b10; p_or = 2'b10; #1;
    chk(p_ov == 2'b10, "R9 buffered token to new active partition", 32'(p_ov), 2);
    chk(p_od[15:8] == 8'h11, "R9 buffered token unchanged", 32'(p_od[15:8]), 32'h11);
    chk(p_ir == 1'b1, "R8 ready while buffer drains", 32'(p_ir), 1);
    settle();
    p_iv = 0; #1;
    chk(p_ov == 2'b10 && p_od[15:8] == 8'h22, "R9 later token follows in order",
        {16'(p_ov), 16'(p_od[15:8])}, {16'h2, 16'h22});
    settle(); #1;
    chk(p_ov == 2'b00, "R8 buffer empty after take", 32'(p_ov), 0);
    chk(p_ir == 1'b1, "R8 empty buffer ready", 32'(p_ir), 1);
  endtask

  initial begin
    t_reset();
    t_bcast_basic();
    t_bcast_drop();
    t_request();
    t_prefetch();
    settle();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule